// File: doc/BRIEF.md
# Two-Port GPIO Pad and Interrupt Controller

This block runs two 8-bit general-purpose I/O ports from a small byte-wide register bus. Each port has a data register, a per-pin interrupt enable register and a 2-bit mode field. The 2-bit mode fields share one configuration register. The mode is set for the whole port and cannot be set per pin. The block combines the mode with each pin's data bit to produce three pad control signals: output enable, output level and pull-up enable. The pad cell uses these to drive the pin, let it float, or pull it weakly high.

Pin levels enter through a two-flop synchronizer. The synchronized level is compared with its value one cycle earlier, and this comparison finds rising and falling edges. The port mode decides which edge direction is counted. An edge sets a sticky per-pin pending bit only when four conditions hold together: the edge direction matches the port mode, the pin's enable bit is set, the global GPIO interrupt enable is high, and the interrupt-sense enable is high. The single interrupt request is the OR of all pending bits. Software clears pending bits by writing ones to them.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset:
  - The configuration register reads 0.
  - The data, enable and pending registers read 0.
  - `pad_oe_o` and `pad_pu_o` are all zero.
  - `irq_o` is low.
- R2: The configuration register is at address 0x08.
  - Port 0 takes the mode from bits 1:0. Port 1 takes the mode from bits 3:2.
  - Bits 7:4 always read 0, and writes to them have no effect.
- R3: Each mode applies to every pin of its port:
  - Mode 00 (floating): the pin is not driven and the pull-up is off.
  - Mode 01 (open drain): the pin is driven low where the data bit is 0. Otherwise it floats. The pull-up is off.
  - Mode 10 (push-pull): every pin is driven to its data bit.
  - Mode 11 (resistive): the pin is driven low where the data bit is 0. Otherwise the pull-up is on.
  - The driven level is always `pad_out_o`.
- R4: The pin interrupt enable registers are at 0x04 (port 0) and 0x05 (port 1). Both are read/write.
- R5: The edge direction that counts depends on the port mode:
  - Modes 00 and 01 count only rising edges (low to high).
  - Mode 11 counts only falling edges (high to low).
- R6: A port in mode 10 never sets a pending bit, whatever the pins do.
- R7: An edge sets a pin's pending bit only when all of these are high in the cycle the edge is seen:
  - the pin's enable bit,
  - `gpio_ie_i`,
  - `sense_en_i`.
- R8: Pending bits are at 0x06 (port 0) and 0x07 (port 1).
  - They stay set until a 1 is written to the same bit. Writing a 0 has no effect.
  - `irq_o` is high while any pending bit is set.
- R9: Pins are synchronized through two flops. The pin state registers at 0x02 and 0x03 show a pin change two clock edges after it happens.
  - A pending bit, and `irq_o`, rise on the third edge after the pin change.
- R10: The data registers are at 0x00 (port 0) and 0x01 (port 1). Both are read/write. Port n uses bits 8n+7:8n of the pad vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| pin_i | input | 16 | Pad input levels (asynchronous) |
| gpio_ie_i | input | 1 | Global GPIO interrupt enable |
| sense_en_i | input | 1 | Global interrupt-sense enable |
| pad_oe_o | output | 16 | Per-pin output enable |
| pad_out_o | output | 16 | Per-pin driven level |
| pad_pu_o | output | 16 | Per-pin pull-up enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after the following corner cases:

- **Edge direction per mode.** It sends each edge direction into the open-drain mode, the resistive mode and the floating mode. A design that decoded polarity from the wrong mode bit would raise an interrupt on the opposite edge.
- **Push-pull mode with live pins.** It toggles the pins of a port in push-pull mode. A design that did not force interrupts off in that mode would set a pending bit.
- **Enable gating.** It removes each of the three enables in turn while an edge occurs. A design that dropped one term from the AND would still interrupt.
- **Write-one-to-clear.** It writes zero to a pending bit, then waits idle cycles. A design that cleared on any write, or that cleared by itself, would drop the request.
- **Synchronizer depth.** It reads the pin state one edge and two edges after a change. An extra or missing flop would show up there.
- **Reserved bits and port-field offsets.** It writes all ones to the configuration register. It also drives port 1 alone. A design that stored the reserved bits, or swapped the port fields, would read back wrong values or drive the wrong pads.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    MODE_HIZ    = 2'b00,
    MODE_ODRAIN = 2'b01,
    MODE_CMOS   = 2'b10,
    MODE_RPULL  = 2'b11
  } pin_mode_e;

  // base addresses; per-port registers sit at base + port index
  localparam int unsigned REG_DATA = 0;
  localparam int unsigned REG_PIN  = 2;
  localparam int unsigned REG_IE   = 4;
  localparam int unsigned REG_PEND = 6;
  localparam int unsigned REG_CFG  = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= d_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign q_o    = s2_q;
  assign rise_o = s2_q & ~prev_q;
  assign fall_o = ~s2_q & prev_q;
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned PORT_W    = 8,
  localparam int unsigned NPINS    = NUM_PORTS * PORT_W
) (
  input  logic [2*NUM_PORTS-1:0] mode_i,
  input  logic [NPINS-1:0]       data_i,
  output logic [NPINS-1:0]       oe_o,
  output logic [NPINS-1:0]       out_o,
  output logic [NPINS-1:0]       pu_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pin_mode_e          mode;
    logic [PORT_W-1:0]  d;
    assign mode = pin_mode_e'(mode_i[2*p +: 2]);
    assign d    = data_i[p*PORT_W +: PORT_W];

    always_comb begin
      oe_o[p*PORT_W +: PORT_W]  = '0;
      out_o[p*PORT_W +: PORT_W] = '0;
      pu_o[p*PORT_W +: PORT_W]  = '0;
      unique case (mode)
        MODE_HIZ:    ;
        MODE_ODRAIN: oe_o[p*PORT_W +: PORT_W] = ~d;
        MODE_CMOS: begin
          oe_o[p*PORT_W +: PORT_W]  = '1;
          out_o[p*PORT_W +: PORT_W] = d;
        end
        MODE_RPULL: begin
          oe_o[p*PORT_W +: PORT_W] = ~d;
          pu_o[p*PORT_W +: PORT_W] = d;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned PORT_W    = 8,
  localparam int unsigned NPINS    = NUM_PORTS * PORT_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2*NUM_PORTS-1:0] mode_i,
  input  logic [NPINS-1:0]       ie_i,
  input  logic [NPINS-1:0]       rise_i,
  input  logic [NPINS-1:0]       fall_i,
  input  logic                   gpio_ie_i,
  input  logic                   sense_en_i,
  input  logic [NPINS-1:0]       clr_i,
  output logic [NPINS-1:0]       pend_o,
  output logic                   irq_o
);
  logic [NPINS-1:0] evt, set, pend_q;
  logic             gate;

  assign gate = gpio_ie_i & sense_en_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pin_mode_e mode;
    assign mode = pin_mode_e'(mode_i[2*p +: 2]);

    always_comb begin
      unique case (mode)
        MODE_HIZ, MODE_ODRAIN: evt[p*PORT_W +: PORT_W] = rise_i[p*PORT_W +: PORT_W];
        MODE_RPULL:            evt[p*PORT_W +: PORT_W] = fall_i[p*PORT_W +: PORT_W];
        default:               evt[p*PORT_W +: PORT_W] = '0;
      endcase
    end

    AST_CMOS_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == MODE_CMOS && pend_q[p*PORT_W +: PORT_W] == '0)
        |=> pend_q[p*PORT_W +: PORT_W] == '0); // R6
  end

  assign set = evt & ie_i & {NPINS{gate}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set;
  end

  assign pend_o = pend_q;
  assign irq_o  = |pend_q;

  AST_GATE_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(gpio_ie_i && sense_en_i) && pend_q == '0) |=> pend_q == '0); // R7

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R8
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned NPINS    = NUM_PORTS * PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              gpio_ie_i,
  input  logic              sense_en_i,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  pad_out_o,
  output logic [NPINS-1:0]  pad_pu_o,
  output logic              irq_o
);
  localparam int unsigned CFG_W = 2 * NUM_PORTS;

  logic [NPINS-1:0] data_q, ie_q, clr, pend, pin_s, rise, fall;
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ie_q   <= '0;
      cfg_q  <= '0;
    end else if (we_i) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (addr_i == ADDR_W'(REG_DATA + p)) data_q[p*PORT_W +: PORT_W] <= wdata_i[PORT_W-1:0];
        if (addr_i == ADDR_W'(REG_IE + p))   ie_q[p*PORT_W +: PORT_W]   <= wdata_i[PORT_W-1:0];
      end
      if (addr_i == ADDR_W'(REG_CFG)) cfg_q <= wdata_i[CFG_W-1:0];
    end
  end

  always_comb begin
    clr     = '0;
    rdata_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (we_i && addr_i == ADDR_W'(REG_PEND + p)) clr[p*PORT_W +: PORT_W] = wdata_i[PORT_W-1:0];
      if (addr_i == ADDR_W'(REG_DATA + p)) rdata_o[PORT_W-1:0] = data_q[p*PORT_W +: PORT_W];
      if (addr_i == ADDR_W'(REG_PIN + p))  rdata_o[PORT_W-1:0] = pin_s[p*PORT_W +: PORT_W];
      if (addr_i == ADDR_W'(REG_IE + p))   rdata_o[PORT_W-1:0] = ie_q[p*PORT_W +: PORT_W];
      if (addr_i == ADDR_W'(REG_PEND + p)) rdata_o[PORT_W-1:0] = pend[p*PORT_W +: PORT_W];
    end
    if (addr_i == ADDR_W'(REG_CFG)) rdata_o[CFG_W-1:0] = cfg_q;
  end

  gpio_sync #(.W(NPINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s),
    .rise_o (rise),
    .fall_o (fall)
  );

  gpio_pad_drv #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_pad (
    .mode_i (cfg_q),
    .data_i (data_q),
    .oe_o   (pad_oe_o),
    .out_o  (pad_out_o),
    .pu_o   (pad_pu_o)
  );

  gpio_irq_unit #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (cfg_q),
    .ie_i       (ie_q),
    .rise_i     (rise),
    .fall_i     (fall),
    .gpio_ie_i  (gpio_ie_i),
    .sense_en_i (sense_en_i),
    .clr_i      (clr),
    .pend_o     (pend),
    .irq_o      (irq_o)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    AST_HIZ_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[2*p +: 2] == MODE_HIZ)
        |-> (pad_oe_o[p*PORT_W +: PORT_W] == '0 && pad_pu_o[p*PORT_W +: PORT_W] == '0)); // R3
    AST_CMOS_DRIVES_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[2*p +: 2] == MODE_CMOS)
        |-> (pad_oe_o[p*PORT_W +: PORT_W] == '1
             && pad_out_o[p*PORT_W +: PORT_W] == data_q[p*PORT_W +: PORT_W])); // R3
  end
endmodule

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, we = 0, gie = 0, sense = 0;
  logic [7:0]  addr = 0, wdata = 0, rdata;
  logic [15:0] pins = 0, oe, outv, pu;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .gpio_ie_i(gie), .sense_en_i(sense),
    .pad_oe_o(oe), .pad_out_o(outv), .pad_pu_o(pu), .irq_o(irq)
  );

  // {mode, data, oe, out, pu} for port 0
  localparam logic [33:0] VEC [6] = '{
    {2'b00, 8'hA5, 8'h00, 8'h00, 8'h00},
    {2'b01, 8'hA5, 8'h5A, 8'h00, 8'h00},
    {2'b10, 8'hA5, 8'hFF, 8'hA5, 8'h00},
    {2'b11, 8'hA5, 8'h5A, 8'h00, 8'hA5},
    {2'b10, 8'h3C, 8'hFF, 8'h3C, 8'h00},
    {2'b11, 8'hFF, 8'h00, 8'h00, 8'hFF}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(logic [15:0] v);
    @(negedge clk); pins = v;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 oe", oe, 0);
    chk("R1 pu", pu, 0);
    chk("R1 irq", irq, 0);
    rd(8'h08, r); chk("R1 cfg", r, 0);
    rd(8'h04, r); chk("R1 ie0", r, 0);
    @(negedge clk); rst_n = 1;

    // register map
    wr(8'h08, 8'hFF); rd(8'h08, r); chk("R2 reserved bits", r, 8'h0F);
    wr(8'h05, 8'h3C); rd(8'h05, r); chk("R4 ie1 readback", r, 8'h3C);
    wr(8'h05, 8'h00);
    wr(8'h01, 8'h81); rd(8'h01, r); chk("R10 data1 readback", r, 8'h81);
    wr(8'h08, 8'h08); #1;
    chk("R2 port1 field oe", oe, 16'hFF00);
    chk("R10 port1 out", outv, 16'h8100);

    // drive table on port 0
    for (int i = 0; i < 6; i++) begin
      wr(8'h08, {6'b0, VEC[i][33:32]});
      wr(8'h00, VEC[i][31:24]);
      #1;
      chk("R3 oe",  oe[7:0],   VEC[i][23:16]);
      chk("R3 out", outv[7:0], VEC[i][15:8]);
      chk("R3 pu",  pu[7:0],   VEC[i][7:0]);
    end

    // synchronizer depth
    wr(8'h08, 8'h00);
    @(negedge clk); addr = 8'h02; pins = 16'h0001;
    @(posedge clk); #1 chk("R9 one edge", rdata, 8'h00);
    @(posedge clk); #1 chk("R9 two edges", rdata, 8'h01);
    pulse(16'h0000);

    // rising edge in open drain, sticky, W1C
    gie = 1; sense = 1;
    wr(8'h08, 8'h01); wr(8'h04, 8'h01);
    @(negedge clk); pins = 16'h0001;
    repeat (2) @(posedge clk); #1 chk("R9 irq not yet", irq, 0);
    @(posedge clk); #1 chk("R9 irq third edge", irq, 1);
    repeat (5) @(posedge clk); #1 chk("R8 sticky", irq, 1);
    rd(8'h06, r); chk("R8 pend0", r, 8'h01);
    wr(8'h06, 8'h00); #1 chk("R8 write zero keeps", irq, 1);
    wr(8'h06, 8'h01); #1 chk("R8 w1c clears", irq, 0);
    pulse(16'h0000); chk("R5 fall ignored open drain", irq, 0);

    // resistive mode: falling only
    wr(8'h08, 8'h03);
    pulse(16'h0001); chk("R5 rise ignored resistive", irq, 0);
    pulse(16'h0000); chk("R5 fall resistive", irq, 1);
    wr(8'h06, 8'hFF);

    // push-pull never interrupts
    wr(8'h08, 8'h02);
    pulse(16'h0001); pulse(16'h0000); chk("R6 cmos no irq", irq, 0);

    // enable gating
    wr(8'h08, 8'h01); wr(8'h04, 8'h02);
    pulse(16'h0001); chk("R7 pin enable off", irq, 0);
    pulse(16'h0000); wr(8'h04, 8'h01); gie = 0;
    pulse(16'h0001); chk("R7 global enable off", irq, 0);
    pulse(16'h0000); gie = 1; sense = 0;
    pulse(16'h0001); chk("R7 sense off", irq, 0);
    pulse(16'h0000); sense = 1;

    // port 1 falling in resistive mode
    wr(8'h08, 8'h0C); wr(8'h05, 8'h80);
    pulse(16'h8000); chk("R5 port1 rise ignored", irq, 0);
    pulse(16'h0000); chk("R5 port1 fall", irq, 1);
    rd(8'h07, r); chk("R8 pend1", r, 8'h80);
    rd(8'h06, r); chk("R8 pend0 clear", r, 8'h00);
    wr(8'h07, 8'h80); #1 chk("R8 port1 w1c", irq, 0);

    // floating mode counts rising edges
    wr(8'h08, 8'h00);
    pulse(16'h0001); chk("R5 hiz rise", irq, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule